// File: doc/BRIEF.md
# Advanced Error Status Logging Unit

This unit records error events seen by a packet-based serial link endpoint or root port. It keeps them in per-type status registers, one group for correctable errors and one for uncorrectable errors. Each error type arrives as a one-cycle strobe. The unit latches the status bit and applies a per-bit mask. For uncorrectable types it also applies a per-bit severity. It then raises a one-cycle report request classed as correctable, non-fatal or fatal, for a message generator downstream to act on. Status bits latch whether or not the type is masked, so software can see suppressed errors.

For uncorrectable errors the unit keeps a first-error pointer and a four-word header log. They hold the oldest unmasked error and the header of the packet that caused it. When software write-1-clears the bit the pointer names, the pointer moves to the lowest-indexed set, unmasked bit that remains. The log is reloaded from a header stored for that type, so software can work through the pending errors one at a time. A small word-addressed register port gives read and write access.

Top module: `aer_log_unit`

## Requirements
- R1: A strobe sets its status bit in the next cycle. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A strobe in the same cycle as a clear of that bit leaves the bit set.
- R2: Both mask registers reset to zero. A correctable type whose mask bit is 1 still latches its status bit but raises no report.
- R3: An uncorrectable type whose mask bit is 1 latches its status bit but raises no report. It is never captured by the first-error pointer.
- R4: Each uncorrectable type has a severity bit: 0 means non-fatal and 1 means fatal. In the cycle after a strobe turns a status bit from 0 to 1 while the type is unmasked, `rpt_fatal_o` or `rpt_nonfatal_o` is high for one cycle. When both classes occur in the same cycle, only `rpt_fatal_o` is raised.
- R5: In the cycle after a strobe turns a correctable status bit from 0 to 1 while the type is unmasked, `rpt_cor_o` is high for one cycle.
- R6: While the pointer holds 31 (none pending), the lowest-indexed unmasked uncorrectable strobe in a cycle loads its index into the pointer. While an error is pending, the pointer holds its value until the pointed-to bit is cleared.
- R7: When the pointer is loaded from a strobe, the log takes `hdr_i` if `hdr_vld_i` is high: word 0 is `hdr_i[31:0]` and word 3 is `hdr_i[127:96]`. Without a valid header the log keeps its contents.
- R8: When the pointed-to bit is cleared, the pointer moves to the lowest-indexed set, unmasked uncorrectable bit, or to 31 if there is none. The log is reloaded if a header is held for that bit. A header is held for every type strobed with `hdr_vld_i` high, until that type's status bit clears.
- R9: The register port uses these word addresses: 0 uncorrectable status, 1 uncorrectable mask, 2 severity, 3 correctable status, 4 correctable mask, 5 pointer (bits 4:0), 6 to 9 log words 0 to 3. Other addresses and unimplemented bits read 0. Uncorrectable bit 18 is the malformed-packet type.
- R10: After reset all status, mask, severity and log registers read 0, the pointer reads 31 and no report is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cor_err_i | input | NUM_COR | Correctable error strobes, one per type |
| unc_err_i | input | NUM_UNC | Uncorrectable error strobes, one per type |
| hdr_i | input | 128 | Offending packet header for this cycle's uncorrectable strobes |
| hdr_vld_i | input | 1 | `hdr_i` is valid |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| rpt_cor_o | output | 1 | Correctable report request |
| rpt_nonfatal_o | output | 1 | Non-fatal report request |
| rpt_fatal_o | output | 1 | Fatal report request |

## Verification
Two functions can land in the same cycle. The first is a software clear of the pointed-to status bit, which advances the pointer. The second is a new strobe, which may set that same bit again or set a lower-indexed bit that should become the next pointer target. The bench provokes this directly: it clears the pointed bit while a new strobe arrives for the same bit or for a lower bit. It then runs a long stretch of random strobes mixed with random clear and mask writes, so these collisions recur. Each cycle is judged against a behavioural model that applies set-wins-over-clear and then chooses the pointer from the merged status. The report outputs and the addressed register are compared on every clock.

// File: rtl/aer_log_pkg.sv
package aer_log_pkg;
  localparam int REG_W     = 32;
  localparam int HDR_W     = 128;
  localparam int LOG_WORDS = 4;
  localparam int PTR_W     = 5;
  localparam logic [PTR_W-1:0] PTR_NONE = 5'd31;

  typedef enum logic [3:0] {
    A_USTAT = 4'd0,
    A_UMASK = 4'd1,
    A_USEV  = 4'd2,
    A_CSTAT = 4'd3,
    A_CMASK = 4'd4,
    A_FEP   = 4'd5,
    A_LOG0  = 4'd6,
    A_LOG1  = 4'd7,
    A_LOG2  = 4'd8,
    A_LOG3  = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/aer_prio_enc.sv
module aer_prio_enc
  import aer_log_pkg::*;
#(
  parameter int W = 27
) (
  input  logic [W-1:0]     vec_i,
  output logic [PTR_W-1:0] idx_o,
  output logic             found_o
);
  always_comb begin
    idx_o   = PTR_NONE;
    found_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = PTR_W'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/aer_cor_bank.sv
module aer_cor_bank #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] err_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         rpt_o
);
  logic [N-1:0] stat_q, mask_q;
  logic         rpt_q;
  logic [N-1:0] fresh;

  assign fresh = err_i & ~stat_q & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      rpt_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | err_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
      rpt_q  <= |fresh;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign rpt_o  = rpt_q;
endmodule

// File: rtl/aer_unc_bank.sv
module aer_unc_bank #(
  parameter int N = 27
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] err_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  input  logic         sev_we_i,
  input  logic [N-1:0] sev_wdata_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] stat_nxt_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] sev_o,
  output logic         rpt_fatal_o,
  output logic         rpt_nonfatal_o
);
  logic [N-1:0] stat_q, mask_q, sev_q;
  logic         fatal_q, nonfatal_q;
  logic [N-1:0] fresh;
  logic         any_fatal, any_nonfatal;

  assign fresh        = err_i & ~stat_q & ~mask_q;
  assign any_fatal    = |(fresh & sev_q);
  assign any_nonfatal = |(fresh & ~sev_q);
  assign stat_nxt_o   = (stat_q & ~clr_i) | err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= '0;
      mask_q     <= '0;
      sev_q      <= '0;
      fatal_q    <= 1'b0;
      nonfatal_q <= 1'b0;
    end else begin
      stat_q     <= stat_nxt_o;
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (sev_we_i)  sev_q  <= sev_wdata_i;
      fatal_q    <= any_fatal;
      nonfatal_q <= any_nonfatal & ~any_fatal;
    end
  end

  assign stat_o         = stat_q;
  assign mask_o         = mask_q;
  assign sev_o          = sev_q;
  assign rpt_fatal_o    = fatal_q;
  assign rpt_nonfatal_o = nonfatal_q;
endmodule

// File: rtl/aer_first_err.sv
module aer_first_err
  import aer_log_pkg::*;
#(
  parameter int N = 27
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N-1:0]                     err_i,
  input  logic [N-1:0]                     mask_i,
  input  logic [N-1:0]                     stat_nxt_i,
  input  logic [HDR_W-1:0]                 hdr_i,
  input  logic                             hdr_vld_i,
  output logic [PTR_W-1:0]                 fep_o,
  output logic [LOG_WORDS-1:0][REG_W-1:0]  log_o
);
  logic [HDR_W-1:0]  store_q [N];
  logic [N-1:0]      held_q, held_nxt;
  logic [PTR_W-1:0]  fep_q, fep_d;
  logic [HDR_W-1:0]  log_q, log_d;
  logic [PTR_W-1:0]  idx_new, idx_adv;
  logic              found_new, found_adv;
  logic [31:0]       stat_pad;
  logic              pending, pt_cleared;
  logic [HDR_W-1:0]  adv_hdr;
  logic              adv_held;

  assign held_nxt = (held_q & stat_nxt_i) | (err_i & {N{hdr_vld_i}});

  aer_prio_enc #(.W(N)) u_enc_new (
    .vec_i  (err_i & ~mask_i),
    .idx_o  (idx_new),
    .found_o(found_new)
  );

  aer_prio_enc #(.W(N)) u_enc_adv (
    .vec_i  (stat_nxt_i & ~mask_i),
    .idx_o  (idx_adv),
    .found_o(found_adv)
  );

  assign stat_pad   = 32'(stat_nxt_i);
  assign pending    = (fep_q != PTR_NONE);
  assign pt_cleared = pending && !stat_pad[fep_q];

  // header for the advance target, including one arriving this cycle
  always_comb begin
    adv_hdr  = '0;
    adv_held = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (idx_adv == PTR_W'(i)) begin
        adv_held = held_nxt[i];
        adv_hdr  = (err_i[i] && hdr_vld_i) ? hdr_i : store_q[i];
      end
    end
  end

  always_comb begin
    fep_d = fep_q;
    log_d = log_q;
    if (!pending) begin
      if (found_new) begin
        fep_d = idx_new;
        if (hdr_vld_i) log_d = hdr_i;
      end
    end else if (pt_cleared) begin
      fep_d = found_adv ? idx_adv : PTR_NONE;
      if (found_adv && adv_held) log_d = adv_hdr;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_store
    always_ff @(posedge clk_i) begin
      if (err_i[g] && hdr_vld_i) store_q[g] <= hdr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      fep_q  <= PTR_NONE;
      log_q  <= '0;
    end else begin
      held_q <= held_nxt;
      fep_q  <= fep_d;
      log_q  <= log_d;
    end
  end

  assign fep_o = fep_q;
  for (genvar w = 0; w < LOG_WORDS; w++) begin : g_log
    assign log_o[w] = log_q[w*REG_W +: REG_W];
  end
endmodule

// File: rtl/aer_log_unit.sv
module aer_log_unit
  import aer_log_pkg::*;
#(
  parameter int NUM_UNC = 27,
  parameter int NUM_COR = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_COR-1:0]   cor_err_i,
  input  logic [NUM_UNC-1:0]   unc_err_i,
  input  logic [127:0]         hdr_i,
  input  logic                 hdr_vld_i,
  input  logic                 reg_we_i,
  input  logic [3:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 rpt_cor_o,
  output logic                 rpt_nonfatal_o,
  output logic                 rpt_fatal_o
);
  logic [NUM_UNC-1:0] unc_stat, unc_stat_nxt, unc_mask, unc_sev, unc_clr;
  logic [NUM_COR-1:0] cor_stat, cor_mask, cor_clr;
  logic [PTR_W-1:0]   fep;
  logic [LOG_WORDS-1:0][REG_W-1:0] log_words;
  logic wr_ustat, wr_umask, wr_usev, wr_cstat, wr_cmask;

  assign wr_ustat = reg_we_i && (reg_addr_i == A_USTAT);
  assign wr_umask = reg_we_i && (reg_addr_i == A_UMASK);
  assign wr_usev  = reg_we_i && (reg_addr_i == A_USEV);
  assign wr_cstat = reg_we_i && (reg_addr_i == A_CSTAT);
  assign wr_cmask = reg_we_i && (reg_addr_i == A_CMASK);

  assign unc_clr = wr_ustat ? reg_wdata_i[NUM_UNC-1:0] : '0;
  assign cor_clr = wr_cstat ? reg_wdata_i[NUM_COR-1:0] : '0;

  aer_cor_bank #(.N(NUM_COR)) u_cor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_i       (cor_err_i),
    .clr_i       (cor_clr),
    .mask_we_i   (wr_cmask),
    .mask_wdata_i(reg_wdata_i[NUM_COR-1:0]),
    .stat_o      (cor_stat),
    .mask_o      (cor_mask),
    .rpt_o       (rpt_cor_o)
  );

  aer_unc_bank #(.N(NUM_UNC)) u_unc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .err_i         (unc_err_i),
    .clr_i         (unc_clr),
    .mask_we_i     (wr_umask),
    .mask_wdata_i  (reg_wdata_i[NUM_UNC-1:0]),
    .sev_we_i      (wr_usev),
    .sev_wdata_i   (reg_wdata_i[NUM_UNC-1:0]),
    .stat_o        (unc_stat),
    .stat_nxt_o    (unc_stat_nxt),
    .mask_o        (unc_mask),
    .sev_o         (unc_sev),
    .rpt_fatal_o   (rpt_fatal_o),
    .rpt_nonfatal_o(rpt_nonfatal_o)
  );

  aer_first_err #(.N(NUM_UNC)) u_first (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_i     (unc_err_i),
    .mask_i    (unc_mask),
    .stat_nxt_i(unc_stat_nxt),
    .hdr_i     (hdr_i),
    .hdr_vld_i (hdr_vld_i),
    .fep_o     (fep),
    .log_o     (log_words)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_USTAT: reg_rdata_o = 32'(unc_stat);
      A_UMASK: reg_rdata_o = 32'(unc_mask);
      A_USEV:  reg_rdata_o = 32'(unc_sev);
      A_CSTAT: reg_rdata_o = 32'(cor_stat);
      A_CMASK: reg_rdata_o = 32'(cor_mask);
      A_FEP:   reg_rdata_o = 32'(fep);
      A_LOG0:  reg_rdata_o = log_words[0];
      A_LOG1:  reg_rdata_o = log_words[1];
      A_LOG2:  reg_rdata_o = log_words[2];
      A_LOG3:  reg_rdata_o = log_words[3];
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/aer_log_unit_chk.sv
module aer_log_unit_chk #(
  parameter int NUM_UNC = 27,
  parameter int NUM_COR = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_COR-1:0] cor_err_i,
  input logic [NUM_UNC-1:0] unc_err_i,
  input logic               reg_we_i,
  input logic [3:0]         reg_addr_i,
  input logic [NUM_UNC-1:0] unc_stat_i,
  input logic [NUM_UNC-1:0] unc_mask_i,
  input logic [NUM_COR-1:0] cor_mask_i,
  input logic [4:0]         fep_i,
  input logic               rpt_cor_i,
  input logic               rpt_nonfatal_i,
  input logic               rpt_fatal_i
);
  AST_STATUS_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|unc_err_i) |=> ((unc_stat_i & $past(unc_err_i)) == $past(unc_err_i))); // R1

  AST_FALL_ONLY_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(unc_stat_i) & ~unc_stat_i)) |-> $past(reg_we_i && reg_addr_i == 4'd0)); // R1

  AST_UNC_RPT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_fatal_i || rpt_nonfatal_i) |-> $past(|(unc_err_i & ~unc_mask_i))); // R3

  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rpt_fatal_i && rpt_nonfatal_i)); // R4

  AST_COR_RPT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_cor_i |-> $past(|(cor_err_i & ~cor_mask_i))); // R5

  AST_FEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fep_i != 5'd31 && !(reg_we_i && reg_addr_i == 4'd0)) |=> $stable(fep_i)); // R6

  AST_FEP_POINTS_AT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fep_i != 5'd31) |-> (|(32'(unc_stat_i) & (32'd1 << fep_i)))); // R8
endmodule

bind aer_log_unit aer_log_unit_chk #(.NUM_UNC(NUM_UNC), .NUM_COR(NUM_COR)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cor_err_i     (cor_err_i),
  .unc_err_i     (unc_err_i),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .unc_stat_i    (unc_stat),
  .unc_mask_i    (unc_mask),
  .cor_mask_i    (cor_mask),
  .fep_i         (fep),
  .rpt_cor_i     (rpt_cor_o),
  .rpt_nonfatal_i(rpt_nonfatal_o),
  .rpt_fatal_i   (rpt_fatal_o)
);

// File: tb/aer_log_unit_tb.sv
module aer_log_unit_tb;
  localparam int NU = 27;
  localparam int NC = 16;
  localparam logic [31:0] UMSK = (32'd1 << NU) - 1;
  localparam logic [31:0] CMSK = (32'd1 << NC) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] cor_err = '0;
  logic [NU-1:0] unc_err = '0;
  logic [127:0]  hdr = '0;
  logic          hdr_vld = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rpt_cor, rpt_nf, rpt_f;

  int checks = 0, fails = 0;

  // reference model state
  logic [31:0]  m_ustat = 0, m_umask = 0, m_usev = 0, m_cstat = 0, m_cmask = 0;
  int           m_fep = 31;
  logic [127:0] m_log = '0;
  logic [127:0] m_hs [32];
  logic [31:0]  m_held = 0;
  logic         e_cor = 0, e_nf = 0, e_f = 0;

  always #5 clk = ~clk;

  aer_log_unit #(.NUM_UNC(NU), .NUM_COR(NC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cor_err_i(cor_err), .unc_err_i(unc_err),
    .hdr_i(hdr), .hdr_vld_i(hdr_vld), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rpt_cor_o(rpt_cor),
    .rpt_nonfatal_o(rpt_nf), .rpt_fatal_o(rpt_f)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ustat;
      4'd1: return m_umask;
      4'd2: return m_usev;
      4'd3: return m_cstat;
      4'd4: return m_cmask;
      4'd5: return 32'(m_fep);
      4'd6: return m_log[31:0];
      4'd7: return m_log[63:32];
      4'd8: return m_log[95:64];
      4'd9: return m_log[127:96];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0, 4'd3: return "R1";
      4'd1, 4'd4: return "R2";
      4'd2: return "R4";
      4'd5: return "R6";
      4'd6, 4'd7, 4'd8, 4'd9: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] ue, ce, clr_u, clr_c, fresh, ustat_n;
    int low;
    ue = 32'(unc_err);
    ce = 32'(cor_err);
    clr_u = (we && addr == 4'd0) ? (wdata & UMSK) : 0;
    clr_c = (we && addr == 4'd3) ? (wdata & CMSK) : 0;
    e_cor = |(ce & ~m_cstat & ~m_cmask);
    fresh = ue & ~m_ustat & ~m_umask;
    e_f   = |(fresh & m_usev);
    e_nf  = |(fresh & ~m_usev) && !e_f;
    ustat_n = (m_ustat & ~clr_u) | ue;
    for (int i = 0; i < NU; i++) begin
      if (ue[i] && hdr_vld) begin m_hs[i] = hdr; m_held[i] = 1'b1; end
      else if (!ustat_n[i]) m_held[i] = 1'b0;
    end
    if (m_fep == 31) begin
      low = -1;
      for (int i = NU - 1; i >= 0; i--) if (ue[i] && !m_umask[i]) low = i;
      if (low >= 0) begin
        m_fep = low;
        if (hdr_vld) m_log = hdr;
      end
    end else if (!ustat_n[m_fep]) begin
      low = -1;
      for (int i = NU - 1; i >= 0; i--) if (ustat_n[i] && !m_umask[i]) low = i;
      if (low >= 0) begin
        m_fep = low;
        if (m_held[low]) m_log = m_hs[low];
      end else m_fep = 31;
    end
    m_ustat = ustat_n;
    m_cstat = (m_cstat & ~clr_c) | ce;
    if (we && addr == 4'd1) m_umask = wdata & UMSK;
    if (we && addr == 4'd2) m_usev  = wdata & UMSK;
    if (we && addr == 4'd4) m_cmask = wdata & CMSK;
  endtask

  // inputs already set at a negedge; clock once and compare
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R5 rpt_cor", 32'(rpt_cor), 32'(e_cor));
    chk("R4 rpt_fatal", 32'(rpt_f), 32'(e_f));
    chk("R4 rpt_nonfatal", 32'(rpt_nf), 32'(e_nf));
    chk({tag_of(addr), " rdata"}, rdata, m_read(addr));
    cor_err = '0; unc_err = '0; hdr_vld = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  task automatic peek(input logic [3:0] a, input string req, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
    chk({req, " model"}, m_read(a), exp);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int a = 0; a < 10; a++) peek(4'(a), "R10 reset", (a == 5) ? 32'd31 : 32'd0);
    chk("R10 no report", {29'd0, rpt_cor, rpt_nf, rpt_f}, 32'd0);

    // R1 set, write-0, clear, set wins over clear
    addr = 4'd3; cor_err[3] = 1'b1; tick();
    peek(4'd3, "R1 set", 32'h8);
    wr(4'd3, 32'h0);
    peek(4'd3, "R1 write0", 32'h8);
    wr(4'd3, 32'h8);
    peek(4'd3, "R1 clear", 32'h0);
    cor_err[3] = 1'b1; tick();
    cor_err[3] = 1'b1; wr(4'd3, 32'h8);
    peek(4'd3, "R1 set wins", 32'h8);

    // R2 masked correctable latches, no report
    wr(4'd4, 32'h20);
    cor_err[5] = 1'b1; addr = 4'd3; tick();
    chk("R2 masked no rpt", 32'(rpt_cor), 32'd0);
    peek(4'd3, "R2 latched", 32'h28);

    // R3 masked uncorrectable
    wr(4'd1, 32'h10);
    unc_err[4] = 1'b1; addr = 4'd5; tick();
    chk("R3 no rpt", 32'(rpt_f | rpt_nf), 32'd0);
    peek(4'd0, "R3 latched", 32'h10);
    peek(4'd5, "R3 no capture", 32'd31);

    // R4 fatal over nonfatal, R6 lowest wins, R7 header capture
    wr(4'd2, 32'h400);
    unc_err[10] = 1'b1; unc_err[12] = 1'b1;
    hdr = 128'h0D0D0D0D_0C0C0C0C_0B0B0B0B_0A0A0A0A; hdr_vld = 1'b1; tick();
    chk("R4 fatal only", {30'd0, rpt_f, rpt_nf}, 32'h2);
    peek(4'd5, "R6 lowest", 32'd10);
    peek(4'd6, "R7 log w0", 32'h0A0A0A0A);
    peek(4'd9, "R7 log w3", 32'h0D0D0D0D);

    // R6 hold while pending; nonfatal report
    unc_err[2] = 1'b1; hdr = {4{32'h22222222}}; hdr_vld = 1'b1; tick();
    chk("R4 nonfatal", {30'd0, rpt_f, rpt_nf}, 32'h1);
    peek(4'd5, "R6 hold", 32'd10);
    peek(4'd6, "R7 log kept", 32'h0A0A0A0A);

    // R8 advance to lowest remaining, reload log
    wr(4'd0, 32'h400);
    peek(4'd5, "R8 advance", 32'd2);
    peek(4'd6, "R8 reload", 32'h22222222);
    // clear pointed bit while strobing it again: pointer holds
    unc_err[2] = 1'b1; wr(4'd0, 32'h4);
    peek(4'd5, "R8 set wins hold", 32'd2);
    // clear bit 2 while lower bit 1 strobes: moves to 1
    unc_err[1] = 1'b1; hdr = {4{32'h11111111}}; hdr_vld = 1'b1; wr(4'd0, 32'h4);
    peek(4'd5, "R8 same-cycle lower", 32'd1);
    peek(4'd7, "R8 log new hdr", 32'h11111111);
    wr(4'd0, 32'h2);
    peek(4'd5, "R8 to 12", 32'd12);
    peek(4'd6, "R8 reload 12", 32'h0A0A0A0A);
    wr(4'd0, 32'h1000);
    peek(4'd5, "R8 none left", 32'd31);

    // R9 malformed bit 18, unused address, unimplemented bits
    unc_err[18] = 1'b1; tick();
    peek(4'd5, "R9 malformed ptr", 32'd18);
    peek(4'd0, "R9 status", 32'h40010);
    peek(4'd12, "R9 unused addr", 32'd0);
    wr(4'd1, 32'hFFFFFFFF);
    peek(4'd1, "R9 mask width", UMSK);
    wr(4'd4, 32'hFFFFFFFF);
    peek(4'd4, "R9 cmask width", CMSK);
    wr(4'd1, 32'h0);
    wr(4'd4, 32'h0);

    // random collisions
    for (int n = 0; n < 3000; n++) begin
      int r;
      unc_err = NU'($urandom & $urandom);
      if ($urandom_range(0, 3) != 0) unc_err = '0;
      cor_err = NC'($urandom & $urandom & $urandom);
      hdr = {$urandom, $urandom, $urandom, $urandom};
      hdr_vld = 1'($urandom);
      r = $urandom_range(0, 9);
      we = (r < 4);
      case (r)
        0, 1: begin addr = 4'd0; wdata = $urandom; end
        2: begin addr = 4'd3; wdata = $urandom; end
        3: begin addr = 4'($urandom_range(1, 4)); wdata = $urandom & $urandom & $urandom; end
        default: begin addr = 4'($urandom_range(0, 11)); wdata = 0; end
      endcase
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule